// File: doc/BRIEF.md
# Two-Stream Serial Audio Transmitter (Bus Master)

This block is the clock master of a serial stereo audio link. It divides its system clock by four to form the bit clock and makes a word-select clock with 64 bit periods per stereo frame. Each frame has a 32-bit left slot and a 32-bit right slot. It shifts two independent stereo streams out MSB first, one on each of two data pins. A configuration input selects the framing for each frame. In I2S framing the MSB comes one bit period after the word-select edge. In MSB-aligned (left-justified) framing the MSB comes in the first bit period of the slot. Each sample carries between 14 and 18 significant bits, and every other slot position is sent as zero.

Once per frame the block raises a one-cycle request strobe a fixed number of system clocks before the next frame begins. The parallel samples, the framing choice and the significant width are captured on that strobe, so all of them stay constant for the whole following frame. The clock and data pins come out as values plus a single pad-enable. A small link state machine with the states LINK_IDLE, LINK_ARMED, LINK_LIVE and LINK_DRAIN moves that enable only at frame boundaries. The transitions are:
- LINK_IDLE to LINK_ARMED when enabled mid-frame.
- LINK_IDLE to LINK_LIVE when enabled in the last cycle of a frame.
- LINK_ARMED to LINK_LIVE at the frame end.
- LINK_ARMED to LINK_IDLE when the enable is withdrawn.
- LINK_LIVE to LINK_DRAIN when disabled mid-frame.
- LINK_LIVE to LINK_IDLE when disabled in the last cycle.
- LINK_DRAIN to LINK_LIVE when re-enabled.
- LINK_DRAIN to LINK_IDLE at the frame end.

Top module: `serial_audio_tx`

## Requirements
- R1: `sck` has a period of 4 system clocks. It is low for the first 2 and high for the last 2, and there are 64 such periods per frame.
- R2: `ws` is low for the 32 bit periods of the left slot and high for the 32 periods of the right slot. It changes only together with a falling `sck`, and a frame begins with `ws` falling.
- R3: `sdo1` and `sdo2` change only when `sck` falls, and each sample is sent MSB first.
- R4: With `fmt_msb`=1 the sample MSB is sent in slot bit period 0, the first after the `ws` edge.
- R5: With `fmt_msb`=0 (I2S) slot bit period 0 carries 0 and the MSB is sent in slot bit period 1.
- R6: With significant width W, the sample is bits [17 -: W] of the 18-bit input. Input bits below them are ignored, and all slot positions outside the W data bits are sent as 0.
- R7: A `sig_bits` value below 14 is used as 14, and a value above 18 is used as 18.
- R8: `sample_req` is high for exactly one system clock in every frame, 8 clocks before the frame starts. The four sample inputs are captured at that clock edge, and changes to them at any other time have no effect on the pins.
- R9: `fmt_msb` and `sig_bits` are captured on the same edge as the samples and apply to the whole next frame.
- R10: During reset and after it, `pad_oe`, `sck` and `ws` are 0, and the first frame carries all-zero data.
- R11: `pad_oe` equals the value `out_en` had in the last system clock of the previous frame, so it rises only in the first cycle of a frame.
- R12: Dropping `out_en` keeps `pad_oe` high until the frame ends. If it is raised again before the frame ends, `pad_oe` does not fall.
- R13: `sdo1` carries stream 1 (`s1_left`, `s1_right`) and `sdo2` carries stream 2, independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four per bit period |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en | input | 1 | Request to drive the link pins |
| fmt_msb | input | 1 | 1 = MSB-aligned framing, 0 = I2S framing |
| sig_bits | input | 5 | Significant bits per sample (clamped to 14..18) |
| s1_left | input | 18 | Stream 1 left sample, MSB at bit 17 |
| s1_right | input | 18 | Stream 1 right sample |
| s2_left | input | 18 | Stream 2 left sample |
| s2_right | input | 18 | Stream 2 right sample |
| sample_req | output | 1 | One-clock strobe; samples are taken at its edge |
| sck | output | 1 | Bit clock value |
| ws | output | 1 | Word-select value, low = left |
| sdo1 | output | 1 | Serial data, stream 1 |
| sdo2 | output | 1 | Serial data, stream 2 |
| pad_oe | output | 1 | Tristate enable for sck, ws, sdo1, sdo2 |

## Verification
A wrong divider or slot counter shows up within one bit period. The bad value appears as a misplaced `sck` edge, or within a slot as a `ws` edge that does not line up with a falling `sck`. A wrong capture register or a wrong framing choice corrupts the data bits of the very next frame, and the first few bit periods of that frame already show it. A link state machine that is in the wrong state shows up at the next frame boundary at the latest, as a `pad_oe` edge away from the `ws` fall or one frame late. The bench compares every output against its own model on every system clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/serial_audio_pkg.sv
package serial_audio_pkg;

    // Pad-drive state of the link
    typedef enum logic [1:0] {
        LINK_IDLE  = 2'd0,
        LINK_ARMED = 2'd1,
        LINK_LIVE  = 2'd2,
        LINK_DRAIN = 2'd3
    } link_state_e;

endpackage

// File: rtl/sat_timing.sv
module sat_timing #(
    parameter int CLK_DIV   = 4,
    parameter int SLOT_BITS = 32,
    parameter int REQ_LEAD  = 8,
    localparam int DW = $clog2(CLK_DIV),
    localparam int PW = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          sck,
    output logic          ws,
    output logic [PW-1:0] slot_pos,
    output logic          frame_end,
    output logic          sample_req
);

    localparam int FRAME_TICKS = 2 * SLOT_BITS * CLK_DIV;
    localparam int REQ_TICK    = FRAME_TICKS - REQ_LEAD;
    localparam int REQ_POS     = (REQ_TICK / CLK_DIV) - SLOT_BITS;
    localparam int REQ_DIV     = REQ_TICK % CLK_DIV;

    logic [DW-1:0] div_q;
    logic [PW-1:0] pos_q;
    logic          ws_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            pos_q <= '0;
            ws_q  <= 1'b0;
        end else if (div_q == DW'(CLK_DIV - 1)) begin
            div_q <= '0;
            if (pos_q == PW'(SLOT_BITS - 1)) begin
                pos_q <= '0;
                ws_q  <= ~ws_q;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        sck        = (div_q >= DW'(CLK_DIV / 2));
        ws         = ws_q;
        slot_pos   = pos_q;
        frame_end  = ws_q && (pos_q == PW'(SLOT_BITS - 1)) && (div_q == DW'(CLK_DIV - 1));
        sample_req = ws_q && (pos_q == PW'(REQ_POS)) && (div_q == DW'(REQ_DIV));
    end

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer #(
    parameter int SAMPLE_W  = 18,
    parameter int SLOT_BITS = 32,
    localparam int PW     = $clog2(SLOT_BITS),
    localparam int WSEL_W = $clog2(SAMPLE_W + 1),
    localparam int IDXW   = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                msb_aligned,
    input  logic [WSEL_W-1:0]   width,
    input  logic                ws,
    input  logic [PW-1:0]       slot_pos,
    output logic                sdo
);

    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic [SAMPLE_W-1:0] cur;
    logic [IDXW-1:0]     idx;
    int                  k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (load) begin
            left_q  <= left_in;
            right_q <= right_in;
        end
    end

    // Slot position to sample bit: I2S framing lags by one bit period
    always_comb begin
        cur = ws ? right_q : left_q;
        k   = int'(slot_pos) - (msb_aligned ? 0 : 1);
        idx = '0;
        sdo = 1'b0;
        if (k >= 0 && k < int'(width)) begin
            idx = IDXW'(SAMPLE_W - 1 - k);
            sdo = cur[idx];
        end
    end

endmodule

// File: rtl/sat_link_fsm.sv
module sat_link_fsm
    import serial_audio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic frame_end,
    output logic pad_oe
);

    link_state_e state_q;
    link_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_IDLE:  if (out_en) state_d = frame_end ? LINK_LIVE : LINK_ARMED;
            LINK_ARMED: if (!out_en) state_d = LINK_IDLE;
                        else if (frame_end) state_d = LINK_LIVE;
            LINK_LIVE:  if (!out_en) state_d = frame_end ? LINK_IDLE : LINK_DRAIN;
            LINK_DRAIN: if (out_en) state_d = LINK_LIVE;
                        else if (frame_end) state_d = LINK_IDLE;
            default:    state_d = LINK_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LINK_LIVE, LINK_DRAIN: pad_oe = 1'b1;
            default:               pad_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx #(
    parameter int CLK_DIV   = 4,
    parameter int SLOT_BITS = 32,
    parameter int SAMPLE_W  = 18,
    parameter int MIN_BITS  = 14,
    parameter int REQ_LEAD  = 8,
    parameter int STREAMS   = 2,
    localparam int WSEL_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                out_en,
    input  logic                fmt_msb,
    input  logic [WSEL_W-1:0]   sig_bits,
    input  logic [SAMPLE_W-1:0] s1_left,
    input  logic [SAMPLE_W-1:0] s1_right,
    input  logic [SAMPLE_W-1:0] s2_left,
    input  logic [SAMPLE_W-1:0] s2_right,
    output logic                sample_req,
    output logic                sck,
    output logic                ws,
    output logic                sdo1,
    output logic                sdo2,
    output logic                pad_oe
);

    localparam int PW = $clog2(SLOT_BITS);

    logic [PW-1:0]       slot_pos;
    logic                frame_end;
    logic                fmt_q;
    logic [WSEL_W-1:0]   width_q;
    logic [WSEL_W-1:0]   width_clamped;
    logic [SAMPLE_W-1:0] left_arr  [STREAMS];
    logic [SAMPLE_W-1:0] right_arr [STREAMS];
    logic [STREAMS-1:0]  sdo_vec;

    sat_timing #(
        .CLK_DIV  (CLK_DIV),
        .SLOT_BITS(SLOT_BITS),
        .REQ_LEAD (REQ_LEAD)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .ws        (ws),
        .slot_pos  (slot_pos),
        .frame_end (frame_end),
        .sample_req(sample_req)
    );

    always_comb begin
        if (sig_bits < WSEL_W'(MIN_BITS))      width_clamped = WSEL_W'(MIN_BITS);
        else if (sig_bits > WSEL_W'(SAMPLE_W)) width_clamped = WSEL_W'(SAMPLE_W);
        else                                   width_clamped = sig_bits;
    end

    // Framing and width are frame-consistent: captured with the samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q   <= 1'b0;
            width_q <= WSEL_W'(SAMPLE_W);
        end else if (sample_req) begin
            fmt_q   <= fmt_msb;
            width_q <= width_clamped;
        end
    end

    always_comb begin
        left_arr[0]  = s1_left;
        right_arr[0] = s1_right;
        left_arr[1]  = s2_left;
        right_arr[1] = s2_right;
    end

    for (genvar g = 0; g < STREAMS; g++) begin : g_stream
        sat_serializer #(
            .SAMPLE_W (SAMPLE_W),
            .SLOT_BITS(SLOT_BITS)
        ) u_ser (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (sample_req),
            .left_in    (left_arr[g]),
            .right_in   (right_arr[g]),
            .msb_aligned(fmt_q),
            .width      (width_q),
            .ws         (ws),
            .slot_pos   (slot_pos),
            .sdo        (sdo_vec[g])
        );
    end

    assign sdo1 = sdo_vec[0];
    assign sdo2 = sdo_vec[1];

    sat_link_fsm u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_en   (out_en),
        .frame_end(frame_end),
        .pad_oe   (pad_oe)
    );

endmodule

// File: rtl/serial_audio_tx_chk.sv
module serial_audio_tx_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic ws,
    input logic sdo1,
    input logic sdo2,
    input logic sample_req,
    input logic pad_oe
);

    logic [7:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_len <= '0;
        else if (sck) hi_len <= hi_len + 1'b1;
        else          hi_len <= '0;
    end

    // R1: each high phase of sck lasts half the divide ratio
    assert_sck_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck) |-> (hi_len == 8'(CLK_DIV / 2)));

    assert_ws_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ws) |-> $fell(sck));

    assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo1) || !$stable(sdo2)) |-> $fell(sck));

    assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |=> !sample_req);

    assert_req_in_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |-> ws);

    assert_oe_rise_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe) |-> ($fell(ws) && !sck));

    assert_oe_fall_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_oe) |-> ($fell(ws) && !sck));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!pad_oe && !sck && !ws && !sample_req)
                else $error("reset state violated");
        end
    end

endmodule

bind serial_audio_tx serial_audio_tx_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck       (sck),
    .ws        (ws),
    .sdo1      (sdo1),
    .sdo2      (sdo2),
    .sample_req(sample_req),
    .pad_oe    (pad_oe)
);

// File: tb/serial_audio_tx_test.sv
module serial_audio_tx_test;

    localparam int FRAME = 256;
    localparam int LEAD  = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        out_en;
    logic        fmt_msb;
    logic [4:0]  sig_bits;
    logic [17:0] s1_left, s1_right, s2_left, s2_right;
    logic        sample_req, sck, ws, sdo1, sdo2, pad_oe;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Reference model state
    int          t;
    bit          m_drive;
    bit          m_fmt;
    int          m_w;
    logic [17:0] m_l1, m_r1, m_l2, m_r2;

    always #5 clk = ~clk;

    serial_audio_tx uut (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .fmt_msb(fmt_msb),
        .sig_bits(sig_bits), .s1_left(s1_left), .s1_right(s1_right),
        .s2_left(s2_left), .s2_right(s2_right), .sample_req(sample_req),
        .sck(sck), .ws(ws), .sdo1(sdo1), .sdo2(sdo2), .pad_oe(pad_oe)
    );

    function automatic int clamp_w(input int v);
        if (v < 14) return 14;   // R7
        if (v > 18) return 18;   // R7
        return v;
    endfunction

    function automatic logic slot_bit(input logic [17:0] s, input int p,
                                      input int w, input bit msb_al);
        int k;
        k = msb_al ? p : p - 1;  // R4 / R5
        if (k >= 0 && k < w) return s[17 - k];
        return 1'b0;             // R6 zero fill
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at t=%0d: actual %b expected %b", tag, t, act, exp);
        end
    endtask

    // Advance the model over the coming clock edge, then compare after it
    task automatic step();
        int p;
        bit e_ws;
        string dtag;
        if (!rst_n) begin
            t = 0; m_drive = 0; m_fmt = 0; m_w = 18;
            m_l1 = '0; m_r1 = '0; m_l2 = '0; m_r2 = '0;
        end else begin
            if (t == FRAME - 1) m_drive = out_en;
            if (t == FRAME - LEAD) begin
                m_l1 = s1_left; m_r1 = s1_right; m_l2 = s2_left; m_r2 = s2_right;
                m_fmt = fmt_msb; m_w = clamp_w(int'(sig_bits));
            end
            t = (t + 1) % FRAME;
        end
        @(negedge clk);
        e_ws = ((t / 4) >= 32);
        p    = (t / 4) % 32;
        if (!rst_n) begin
            check("R10 sck", sck, 1'b0);
            check("R10 ws", ws, 1'b0);
            check("R10 pad_oe", pad_oe, 1'b0);
            check("R10 sdo1", sdo1, 1'b0);
            check("R10 sdo2", sdo2, 1'b0);
        end else begin
            check("R1 sck", sck, (t % 4) >= 2);
            check("R2 ws", ws, e_ws);
            check("R8 sample_req", sample_req, t == FRAME - LEAD);
            check("R11/R12 pad_oe", pad_oe, m_drive);
            dtag = m_fmt ? "R3/R4/R6 sdo1" : "R3/R5/R6 sdo1";
            check(dtag, sdo1, slot_bit(e_ws ? m_r1 : m_l1, p, m_w, m_fmt));
            check("R13 sdo2", sdo2, slot_bit(e_ws ? m_r2 : m_l2, p, m_w, m_fmt));
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        rst_n = 0; out_en = 0; fmt_msb = 1; sig_bits = 5'd18;
        s1_left = 18'h2A5C3; s1_right = 18'h15A3C;
        s2_left = 18'h3C00F; s2_right = 18'h00FF0;
        run(6);                         // R10 reset state
        rst_n = 1;
        run(300);                       // R10 first frame all zero; R4 afterwards
        out_en = 1;                     // R11 enable mid-frame
        run(400);
        s1_left = 18'h3FFFF; s1_right = 18'h20001;   // R8 changes away from strobe
        fmt_msb = 0;                    // R5, R9 switch to I2S mid-frame
        run(512);
        sig_bits = 5'd14;               // R6 low input bits ignored
        s1_left = 18'h1FFFF; s2_right = 18'h0ABCD;
        run(300);
        sig_bits = 5'd9;                // R7 clamp up
        run(300);
        sig_bits = 5'd31;               // R7 clamp down
        s2_left = 18'h1234F;
        run(300);
        sig_bits = 5'd16; fmt_msb = 1;  // R13 distinct streams
        s1_left = 18'h0F0F0; s1_right = 18'h33333;
        s2_left = 18'h3CCCC; s2_right = 18'h2AAAA;
        run(300);
        out_en = 0;                     // R12 drop then restore before boundary
        run(20);
        out_en = 1;
        run(300);
        out_en = 0;                     // R12 drop, pad_oe falls at frame start
        run(300);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule